// File: doc/BRIEF.md
# Burst Data-Transfer Target with Two-Sided Ready Handshake

This block is the responding side of a synchronous, multiplexed address/data burst bus in which every control signal is active low and sampled on the rising clock edge. An initiator opens a transaction by pulling the frame line low for one address cycle. In that cycle it places a byte address on the shared data lines and a four-bit command on the command/byte-enable lines. The target decodes that cycle and claims the transaction when it is a memory read or memory write aimed at its own address window. It then serves an unbounded run of data phases from a small internal word-addressed register file. A word moves only on an edge where both the initiator-ready and target-ready lines are low, and the word index advances after every completed word.

The initiator marks its final data phase by raising frame while it still holds initiator-ready low. A read begins with one turnaround cycle, in which the target claims the transaction but neither drives the data lines nor signals ready. If a burst would run past the top word of the window, the target raises its stop line together with ready on that top word. It then keeps stop low until the initiator withdraws frame. The shared data lines appear as a separate input, output and output-enable.

Top module: `bt_target`

## Requirements
- R1: During reset and after it, with no transaction under way, the device-select, target-ready and stop outputs are high and the output enable is low.
- R2: The target claims a transaction when, in the first cycle with frame low after a cycle with frame high, the command is memory read (0110) or memory write (0111), the address lies in the window (bits 31..6 equal those of the base), and address bits 1..0 are 00. It claims by driving device-select low in the next cycle, and target-ready and stop are only ever low while device-select is low.
- R3: Any other command, an address outside the window, or nonzero address bits 1..0 leave device-select and target-ready high throughout the transaction, and the register file is left unchanged.
- R4: On a write, target-ready is low from the first cycle after the address cycle, and a word is stored into the word selected by address bits 5..2 on each edge where initiator-ready and target-ready are both low.
- R5: During a write data phase, command/byte-enable bit b low writes byte lane b (data bits 8b+7..8b) and bit b high keeps that lane's old value.
- R6: On a read, the first cycle after the address cycle has device-select low, target-ready high and output enable low. From the next cycle the target drives the data lines with target-ready low.
- R7: While target-ready is low on a read, the data output equals the stored word at the current index.
- R8: The index advances by one after each completed word. A cycle with initiator-ready high leaves the index, the data output and target-ready unchanged.
- R9: A word completed while frame is high ends the transaction: in the next cycle device-select, target-ready and stop are high and the output enable is low.
- R10: Stop is low together with target-ready exactly while the current word is the last word of the window. If that word completes with frame still low, target-ready goes high while stop and device-select stay low until frame is seen high, and all three are high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Transaction frame from initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in address cycle, active-low byte enables in data cycles |
| ad_in | input | 32 | Multiplexed address/data lines as seen by the target |
| ad_out | output | 32 | Read data driven onto the data lines |
| ad_oe | output | 1 | Output enable for ad_out |
| devsel_n | output | 1 | Device select (claim), active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Disconnect request, active low |

## Verification
Device-select is due one edge after the address cycle. On a write, target-ready is due at that same edge. On a read it is due one edge later, after the turnaround cycle. A completed word shows its effects one edge after the transfer edge: the next read word or the release of the handshake lines. The bench drives and samples at falling edges. It decides whether a word moves from the ready levels it sees at the falling edge before the transfer edge, and checks the following state one falling edge later. Expected read data, stop placement and disconnect lengths come from a byte-lane model and from simple index arithmetic. The bench sweeps every start word, several burst lengths and several initiator wait patterns.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_DATA = 2'd2,
    ST_HOLD = 2'd3
  } bt_state_e;

  localparam logic [3:0] CMD_MRD = 4'b0110;
  localparam logic [3:0] CMD_MWR = 4'b0111;

endpackage

// File: rtl/bt_rst_sync.sv
module bt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/bt_decode.sv
module bt_decode #(
  parameter int               BUS_W = 32,
  parameter int               DEPTH = 16,
  parameter logic [BUS_W-1:0] BASE  = 32'h0000_1000,
  localparam int              IW    = $clog2(DEPTH),
  localparam int              WB    = IW + 2
) (
  input  logic [BUS_W-1:0] ad,
  input  logic [3:0]       cmd,
  output logic             claim,
  output logic             rd_cmd,
  output logic [IW-1:0]    idx
);
  import bt_pkg::*;

  logic in_win;
  logic aligned;
  logic cmd_ok;

  always_comb begin
    in_win  = (ad[BUS_W-1:WB] == BASE[BUS_W-1:WB]);
    aligned = (ad[1:0] == 2'b00);
    cmd_ok  = (cmd == CMD_MRD) || (cmd == CMD_MWR);
    claim   = in_win && aligned && cmd_ok;
    rd_cmd  = (cmd == CMD_MRD);
    idx     = ad[WB-1:2];
  end

endmodule

// File: rtl/bt_regfile.sv
module bt_regfile #(
  parameter int  BUS_W = 32,
  parameter int  DEPTH = 16,
  localparam int IW    = $clog2(DEPTH),
  localparam int BEW   = BUS_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IW-1:0]    idx,
  input  logic [BEW-1:0]   be,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata
);

  logic [BUS_W-1:0] mem_q [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    for (genvar b = 0; b < BEW; b++) begin : g_lane
      logic lane_en;
      assign lane_en = we && (idx == IW'(w)) && be[b];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mem_q[w][8*b +: 8] <= 8'h00;
        else if (lane_en) mem_q[w][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  assign rdata = mem_q[idx];

endmodule

// File: rtl/bt_ctrl.sv
module bt_ctrl #(
  parameter int  DEPTH = 16,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic          claim,
  input  logic          rd_cmd,
  input  logic [IW-1:0] start_idx,
  output logic [IW-1:0] idx,
  output logic          wr_en,
  output logic          drive,
  output logic          devsel_n,
  output logic          trdy_n,
  output logic          stop_n
);
  import bt_pkg::*;

  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

  bt_state_e     state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          idx_en;
  logic          rd_q, rd_d, rd_en;
  logic          frame_q;
  logic          addr_phase;
  logic          last;
  logic          xfer;

  assign addr_phase = !frame_n && frame_q;
  assign last       = (idx_q == LAST_IDX);
  assign xfer       = (state_q == ST_DATA) && !irdy_n;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    rd_d    = rd_q;
    rd_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (addr_phase && claim) begin
          state_d = rd_cmd ? ST_TURN : ST_DATA;
          idx_d   = start_idx;
          idx_en  = 1'b1;
          rd_d    = rd_cmd;
          rd_en   = 1'b1;
        end
      end
      ST_TURN: state_d = ST_DATA;
      ST_DATA: begin
        if (xfer) begin
          if (frame_n)   state_d = ST_IDLE;
          else if (last) state_d = ST_HOLD;
          else begin
            idx_d  = idx_q + 1'b1;
            idx_en = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (frame_n) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rd_q    <= 1'b0;
      frame_q <= 1'b1;
    end else begin
      state_q <= state_d;
      frame_q <= frame_n;
      if (idx_en) idx_q <= idx_d;
      if (rd_en)  rd_q  <= rd_d;
    end
  end

  assign idx      = idx_q;
  assign wr_en    = xfer && !rd_q;
  assign drive    = rd_q && (state_q == ST_DATA);
  assign devsel_n = (state_q == ST_IDLE);
  assign trdy_n   = (state_q != ST_DATA);
  assign stop_n   = !(((state_q == ST_DATA) && last) || (state_q == ST_HOLD));

endmodule

// File: rtl/bt_target.sv
module bt_target #(
  parameter int               BUS_W = 32,
  parameter int               DEPTH = 16,
  parameter logic [BUS_W-1:0] BASE  = 32'h0000_1000,
  localparam int              IW    = $clog2(DEPTH),
  localparam int              BEW   = BUS_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic [BEW-1:0]   cbe_n,
  input  logic [BUS_W-1:0] ad_in,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic             stop_n
);

  logic             rst_core_n;
  logic             claim;
  logic             rd_cmd;
  logic [IW-1:0]    start_idx;
  logic [IW-1:0]    cur_idx;
  logic             wr_en;
  logic             drive;
  logic [BUS_W-1:0] rdata;

  bt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  bt_decode #(.BUS_W(BUS_W), .DEPTH(DEPTH), .BASE(BASE)) u_dec (
    .ad     (ad_in),
    .cmd    (cbe_n[3:0]),
    .claim  (claim),
    .rd_cmd (rd_cmd),
    .idx    (start_idx)
  );

  bt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .claim     (claim),
    .rd_cmd    (rd_cmd),
    .start_idx (start_idx),
    .idx       (cur_idx),
    .wr_en     (wr_en),
    .drive     (drive),
    .devsel_n  (devsel_n),
    .trdy_n    (trdy_n),
    .stop_n    (stop_n)
  );

  bt_regfile #(.BUS_W(BUS_W), .DEPTH(DEPTH)) u_rf (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (wr_en),
    .idx   (cur_idx),
    .be    (~cbe_n),
    .wdata (ad_in),
    .rdata (rdata)
  );

  assign ad_oe  = drive;
  assign ad_out = drive ? rdata : '0;

endmodule

// File: rtl/bt_target_chk.sv
module bt_target_chk #(
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_n,
  input logic             irdy_n,
  input logic [3:0]       cmd_n,
  input logic [BUS_W-1:0] ad_out,
  input logic             ad_oe,
  input logic             devsel_n,
  input logic             trdy_n,
  input logic             stop_n
);

  assert_trdy_needs_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n || !stop_n || ad_oe) |-> !devsel_n);

  assert_no_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_n) && !frame_n && devsel_n && (cmd_n != 4'b0110) && (cmd_n != 4'b0111))
    |=> devsel_n);

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> $past(!devsel_n && trdy_n));

  assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n && !frame_n) |=> (!trdy_n && $stable(ad_out)));

  assert_final_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && !irdy_n && !trdy_n) |=> (devsel_n && trdy_n && stop_n && !ad_oe));

  assert_disc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && !irdy_n && !trdy_n && !stop_n) |=> (!stop_n && trdy_n && !devsel_n));

endmodule

bind bt_target bt_target_chk #(.BUS_W(BUS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frame_n  (frame_n),
  .irdy_n   (irdy_n),
  .cmd_n    (cbe_n[3:0]),
  .ad_out   (ad_out),
  .ad_oe    (ad_oe),
  .devsel_n (devsel_n),
  .trdy_n   (trdy_n),
  .stop_n   (stop_n)
);

// File: tb/bt_target_tb.sv
module bt_target_tb;

  localparam int          W     = 32;
  localparam int          DEPTH = 16;
  localparam logic [31:0] BASE  = 32'h0000_1000;
  localparam logic [3:0]  MRD   = 4'b0110;
  localparam logic [3:0]  MWR   = 4'b0111;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_n, irdy_n;
  logic [3:0]    cbe_n;
  logic [W-1:0]  ad_in, ad_out;
  logic          ad_oe, devsel_n, trdy_n, stop_n;

  int            n_chk = 0;
  int            n_fail = 0;
  logic [31:0]   model [DEPTH];

  always #2 clk = ~clk;

  bt_target #(.BUS_W(W), .DEPTH(DEPTH), .BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wdata(input logic [31:0] addr, input int k);
    return (addr * 32'h9E37_79B1) ^ (k * 32'h0101_0101) ^ 32'h5A5A_0000;
  endfunction

  task automatic run_txn(input logic [31:0] addr, input logic [3:0] cmd, input int n,
                         input logic [3:0] be, input int wmod);
    bit   rd      = (cmd == MRD);
    bit   claimed = (addr[31:6] == BASE[31:6]) && (addr[1:0] == 2'b00) && (cmd == MRD || cmd == MWR);
    int   idx     = int'(addr[5:2]);
    int   exp_n   = claimed ? ((n < DEPTH - idx) ? n : DEPTH - idx) : 0;
    int   k       = 0;
    int   guard   = 0;
    bit   waited  = 0;
    bit   want_wait, xfer;
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
    @(negedge clk);
    if (!claimed) begin
      frame_n = 1'b1; irdy_n = 1'b0; ad_in = wdata(addr, 99); cbe_n = 4'h0;
      for (int c = 0; c < 5; c++) begin
        chk(devsel_n && trdy_n, "R3 unclaimed select/ready", {30'd0, devsel_n, trdy_n}, 32'h3);
        @(negedge clk);
      end
      irdy_n = 1'b1;
      @(negedge clk);
      return;
    end
    chk(!devsel_n, "R2 claim one cycle after address", {31'd0, devsel_n}, 32'h0);
    if (rd) chk(trdy_n && !ad_oe, "R6 turnaround", {30'd0, trdy_n, ad_oe}, 32'h2);
    else    chk(!trdy_n, "R4 write ready without wait", {31'd0, trdy_n}, 32'h0);
    while (k < exp_n && guard < 200) begin
      guard++;
      want_wait = (wmod != 0) && ((k % wmod) == 1) && !waited;
      irdy_n  = want_wait;
      frame_n = (k == n - 1) && !want_wait;
      ad_in   = rd ? 32'h0 : wdata(addr, k);
      cbe_n   = rd ? 4'h0 : ~be;
      xfer    = !want_wait && !trdy_n;
      if (!trdy_n) begin
        chk(stop_n == !(idx + k == DEPTH - 1), "R10 stop on last window word",
            {31'd0, stop_n}, {31'd0, !(idx + k == DEPTH - 1)});
        if (rd) begin
          chk(ad_oe, "R6 drive after turnaround", {31'd0, ad_oe}, 32'h1);
          chk(ad_out == model[idx + k], waited ? "R8 data held over wait" : "R7 read word",
              ad_out, model[idx + k]);
        end
      end
      if (xfer && !rd)
        for (int b = 0; b < 4; b++)
          if (be[b]) model[idx + k][8*b +: 8] = wdata(addr, k) >> (8 * b);
      @(negedge clk);
      if (xfer) begin k++; waited = 0; end
      else if (want_wait && !trdy_n) waited = 1;
    end
    chk(k == exp_n, "R8 burst progress", k, exp_n);
    if (exp_n < n) begin
      chk(!stop_n && trdy_n && !devsel_n, "R10 hold stop until frame high",
          {29'd0, stop_n, trdy_n, devsel_n}, 32'h2);
      frame_n = 1'b1; irdy_n = 1'b1;
      @(negedge clk);
      chk(devsel_n && trdy_n && stop_n, "R10 release after disconnect",
          {29'd0, stop_n, trdy_n, devsel_n}, 32'h7);
    end else begin
      irdy_n = 1'b1; frame_n = 1'b1;
      chk(devsel_n && trdy_n && stop_n && !ad_oe, "R9 release after final word",
          {28'd0, devsel_n, trdy_n, stop_n, ad_oe}, 32'hE);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'h0; ad_in = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk(devsel_n && trdy_n && stop_n && !ad_oe, "R1 outputs in reset",
        {28'd0, devsel_n, trdy_n, stop_n, ad_oe}, 32'hE);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(devsel_n && trdy_n && stop_n && !ad_oe, "R1 outputs after reset",
        {28'd0, devsel_n, trdy_n, stop_n, ad_oe}, 32'hE);
    run_txn(BASE, MRD, 2, 4'h0, 0);                      // R7 reset contents
    for (int s = 0; s < DEPTH; s++) run_txn(BASE + 4*s, MWR, 3, 4'hF, s % 3); // R4 R10
    run_txn(BASE, MRD, DEPTH, 4'h0, 0);
    for (int s = 0; s < DEPTH; s++) run_txn(BASE + 4*s, MRD, 4, 4'h0, s % 3); // R7 R8 R10
    run_txn(BASE + 20, MWR, 2, 4'b0101, 0);              // R5
    run_txn(BASE + 32, MWR, 3, 4'b1010, 2);              // R5
    run_txn(BASE + 16, MRD, 6, 4'h0, 0);
    run_txn(BASE + 64, MWR, 2, 4'hF, 0);                 // R3 outside window
    run_txn(BASE - 4, MWR, 2, 4'hF, 0);                  // R3 below window
    run_txn(BASE + 4, 4'b0011, 2, 4'hF, 0);              // R3 other command
    run_txn(BASE + 4, 4'b1010, 2, 4'hF, 0);              // R3 other command
    run_txn(BASE + 5, MWR, 2, 4'hF, 0);                  // R3 nonzero low bits
    run_txn(BASE, MRD, DEPTH + 2, 4'h0, 0);              // R3 contents unchanged
    run_txn(BASE, MWR, DEPTH, 4'hF, 2);                  // R8 waits on write
    run_txn(BASE, MRD, DEPTH, 4'h0, 3);                  // R8 waits on read
    run_txn(BASE + 48, MRD, 4, 4'h0, 0);                 // R9 R10 final word is top
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule